// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex synchronous serial port. A host reaches it through a small register window. Data goes out on `txd_o` and comes in on `rxd_i`. Both lines are timed by a serial clock `sclk_o`, which the block derives from its system clock. Frames are 8 bits long and are sent least significant bit first. Each register has a double-buffer stage: the host writes the next byte while the current one shifts, and reads the last received byte while the next one is being captured. Three status flags track progress: transmit-empty, receive-full and overrun. Every 0-to-1 rise of transmit-empty or receive-full sends a one-cycle request to the host and to a transfer controller.

The host port has no back-pressure. A read or write completes in the cycle in which it is presented. The caller keeps to the flag protocol: wait for transmit-empty before writing a byte, and wait for receive-full before reading one. Flags clear only on an explicit acknowledgement. That is either a write of 0 to a flag that the host has already seen as 1, or a data access that carries the transfer-controller acknowledge.

An overrun is a receive frame that completes while the previous byte is still unread. It sets the overrun flag and stops the port in both directions until the host clears that flag.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, status reads 0x01, the control register reads 0, and `txd_o` and `sclk_o` are both high. The status bits are: bit 0 transmit-empty, bit 1 receive-full, bit 2 overrun.
- R2: A frame has `DATA_W` bits, least significant first. `sclk_o` idles high between frames. Each half period lasts `DIV_HALF` clocks, low half first. `txd_o` changes only on falling edges, and `rxd_i` is sampled on rising edges.
- R3: With transmit enabled, a frame starts only while transmit data is pending, and reception runs alongside it if receive is enabled. With receive enabled alone, frames run back to back and `txd_o` stays high.
- R4: Control bit 0 enables transmit and bit 1 enables receive. Setting an enable bit takes effect only if the other enable bit is currently 0. Clearing an enable bit always takes effect, so entering full duplex takes a write of both bits from the all-zero state.
- R5: Transmit-empty rises when a pending byte moves into the shift register. Every rise of the flag gives a one-cycle pulse on `txe_irq_o`.
- R6: When a receive frame completes with receive-full at 0, the byte goes into the receive register, receive-full rises and `rxf_irq_o` pulses for one cycle.
- R7: A receive frame that completes while receive-full is still 1 sets overrun and leaves the receive register unchanged. While overrun is 1, no frame starts in either direction and `sclk_o` stays high.
- R8: A write of 0 to a status bit clears that flag only if an earlier status read returned it as 1. A write of 1 leaves the flag unchanged, and so does a write of 0 without that earlier read.
- R9: A transmit data write with `xfer_ack` high clears transmit-empty. A receive data read with `xfer_ack` high clears receive-full.
- R10: Whenever transmit is disabled, transmit-empty reads 1.
- R11: The register addresses are: 0 control, 1 status, 2 transmit data (reads back the last byte written), 3 receive data. `host_rdata` is combinational while `host_rd` is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| xfer_ack | input | 1 | Transfer-controller acknowledge that goes with a data access |
| sclk_o | output | 1 | Serial clock, idles high |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| txe_irq_o | output | 1 | Transmit-empty request pulse |
| rxf_irq_o | output | 1 | Receive-full request pulse |

## Verification
The properties assume these things about the inputs:
- The host never asserts `host_rd` and `host_wr` in the same cycle.
- `rxd_i` only changes while `sclk_o` is low.
- Status clears are issued as full writes to address 1.

The bench keeps to these rules. One process issues every host access through read and write tasks that hold a strobe for exactly one cycle. A separate driver updates `rxd_i` only on falling serial clock edges, and for each frame it pushes the byte it sends into the receive scoreboard queue. Overrun is produced on purpose by holding off the host reads. Full duplex is entered only from the all-zero control state, except in the case that checks a refused transition.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_TX = 0;
  localparam int unsigned CTL_RX = 1;
  localparam int unsigned ST_TXE = 0;
  localparam int unsigned ST_RXF = 1;
  localparam int unsigned ST_OVR = 2;
  localparam int unsigned N_FLAGS = 3;
endpackage

// File: rtl/sxc_clk_div.sv
module sxc_clk_div #(
  parameter int unsigned DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_comb tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sxc_shift_engine.sv
module sxc_shift_engine #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              ovr,
  input  logic              txe,
  input  logic [DATA_W-1:0] tdr,
  input  logic              rxd,
  output logic              load_tx,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sclk,
  output logic              txd,
  output logic              busy
);
  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [BW-1:0]     bit_idx;
  logic              high_ph, frm_tx, frm_rx, tick, start, last;

  sxc_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  always_comb begin
    start   = !busy && !ovr && ((tx_en && !txe) || (rx_en && !tx_en));
    load_tx = start && tx_en && !txe;
    last    = busy && tick && high_ph && (bit_idx == LAST_BIT);
    rx_done = last && frm_rx;
    rx_byte = rx_sh;
    txd     = frm_tx ? tx_sh[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b1;
      high_ph <= 1'b0;
      bit_idx <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      frm_tx  <= 1'b0;
      frm_rx  <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      sclk    <= 1'b0;
      high_ph <= 1'b0;
      bit_idx <= '0;
      frm_tx  <= load_tx;
      frm_rx  <= rx_en;
      if (load_tx) tx_sh <= tdr;
    end else if (busy && tick) begin
      if (!high_ph) begin
        sclk    <= 1'b1;
        high_ph <= 1'b1;
        rx_sh   <= {rxd, rx_sh[DATA_W-1:1]};
      end else if (bit_idx == LAST_BIT) begin
        busy    <= 1'b0;
        high_ph <= 1'b0;
        frm_tx  <= 1'b0;
      end else begin
        sclk    <= 1'b0;
        high_ph <= 1'b0;
        bit_idx <= bit_idx + 1'b1;
        tx_sh   <= tx_sh >> 1;
      end
    end
  end
endmodule

// File: rtl/sxc_host_regs.sv
module sxc_host_regs
  import sxc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [1:0]         host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic               xfer_ack,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               load_tx,
  input  logic               rx_done,
  input  logic [DATA_W-1:0]  rx_byte,
  output logic               tx_en,
  output logic               rx_en,
  output logic [DATA_W-1:0]  tdr,
  output logic [N_FLAGS-1:0] flags,
  output logic               txe_irq,
  output logic               rxf_irq
);
  logic [1:0]         ctrl_q, ctrl_d;
  logic [N_FLAGS-1:0] fl_q, fl_d, arm_q, arm_d;
  logic [DATA_W-1:0]  tdr_q, tdr_d, rdr_q, rdr_d;
  logic               wr_ctrl, wr_stat, wr_tx, rd_stat, rd_rx;

  always_comb begin
    wr_ctrl = host_wr && (host_addr == REG_CTRL);
    wr_stat = host_wr && (host_addr == REG_STAT);
    wr_tx   = host_wr && (host_addr == REG_TXD);
    rd_stat = host_rd && (host_addr == REG_STAT);
    rd_rx   = host_rd && (host_addr == REG_RXD);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      for (int i = 0; i < 2; i++)
        ctrl_d[i] = host_wdata[i] & (ctrl_q[i] | ~ctrl_q[1-i]);
    end

    fl_d  = fl_q;
    tdr_d = tdr_q;
    rdr_d = rdr_q;
    if (wr_stat) begin
      for (int f = 0; f < N_FLAGS; f++)
        if (arm_q[f] && !host_wdata[f]) fl_d[f] = 1'b0;
    end
    if (wr_tx) begin
      tdr_d = host_wdata;
      if (xfer_ack) fl_d[ST_TXE] = 1'b0;
    end
    if (rd_rx && xfer_ack) fl_d[ST_RXF] = 1'b0;
    if (load_tx) fl_d[ST_TXE] = 1'b1;
    if (rx_done) begin
      if (fl_d[ST_RXF]) fl_d[ST_OVR] = 1'b1;
      else begin
        fl_d[ST_RXF] = 1'b1;
        rdr_d        = rx_byte;
      end
    end
    if (!ctrl_d[CTL_TX]) fl_d[ST_TXE] = 1'b1;

    arm_d = (rd_stat ? (arm_q | fl_q) : arm_q) & fl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fl_q    <= N_FLAGS'(1) << ST_TXE;
      arm_q   <= '0;
      tdr_q   <= '0;
      rdr_q   <= '0;
      txe_irq <= 1'b0;
      rxf_irq <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      fl_q    <= fl_d;
      arm_q   <= arm_d;
      tdr_q   <= tdr_d;
      rdr_q   <= rdr_d;
      txe_irq <= fl_d[ST_TXE] & ~fl_q[ST_TXE];
      rxf_irq <= fl_d[ST_RXF] & ~fl_q[ST_RXF];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      unique case (host_addr)
        REG_CTRL: host_rdata = DATA_W'(ctrl_q);
        REG_STAT: host_rdata = DATA_W'(fl_q);
        REG_TXD:  host_rdata = tdr_q;
        default:  host_rdata = rdr_q;
      endcase
    end
    tx_en = ctrl_q[CTL_TX];
    rx_en = ctrl_q[CTL_RX];
    tdr   = tdr_q;
    flags = fl_q;
  end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sxc_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              xfer_ack,
  output logic              sclk_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              txe_irq_o,
  output logic              rxf_irq_o
);
  logic               tx_en, rx_en, load_tx, rx_done, busy;
  logic [DATA_W-1:0]  tdr, rx_byte;
  logic [N_FLAGS-1:0] flags;

  sxc_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .xfer_ack  (xfer_ack),
    .host_rdata(host_rdata),
    .load_tx   (load_tx),
    .rx_done   (rx_done),
    .rx_byte   (rx_byte),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .tdr       (tdr),
    .flags     (flags),
    .txe_irq   (txe_irq_o),
    .rxf_irq   (rxf_irq_o)
  );

  sxc_shift_engine #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en  (tx_en),
    .rx_en  (rx_en),
    .ovr    (flags[ST_OVR]),
    .txe    (flags[ST_TXE]),
    .tdr    (tdr),
    .rxd    (rxd_i),
    .load_tx(load_tx),
    .rx_done(rx_done),
    .rx_byte(rx_byte),
    .sclk   (sclk_o),
    .txd    (txd_o),
    .busy   (busy)
  );
endmodule

// File: rtl/sxc_checker.sv
module sxc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctrl,
  input logic [2:0] flags,
  input logic       busy,
  input logic       sclk,
  input logic       txd,
  input logic       txe_irq,
  input logic       rxf_irq,
  input logic       host_wr,
  input logic [1:0] host_addr,
  input logic [2:0] wdata_lo
);
  // R2
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sclk && $past(sclk)) |-> $stable(txd));

  // R4
  duplex_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 2'b11 && $past(ctrl) != 2'b11) |-> ($past(ctrl) == 2'b00));

  // R5
  txe_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txe_irq |-> flags[0]);

  // R6
  rxf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> rxf_irq);

  // R7
  ovr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && sclk) |=> sclk);

  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[2]) |-> $past(host_wr && host_addr == 2'd1 && !wdata_lo[2]));

  // R10
  txe_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> flags[0]);
endmodule

bind sync_serial_xcvr sxc_checker u_sxc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl     ({rx_en, tx_en}),
  .flags    (flags),
  .busy     (busy),
  .sclk     (sclk_o),
  .txd      (txd_o),
  .txe_irq  (txe_irq_o),
  .rxf_irq  (rxf_irq_o),
  .host_wr  (host_wr),
  .host_addr(host_addr),
  .wdata_lo (host_wdata[2:0])
);

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;
  localparam int DW = 8;
  localparam int DH = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          host_rd = 1'b0, host_wr = 1'b0, xfer_ack = 1'b0, rxd_i = 1'b1;
  logic [1:0]    host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          sclk_o, txd_o, txe_irq_o, rxf_irq_o;

  always #4 clk = ~clk;

  sync_serial_xcvr #(.DATA_W(DW), .DIV_HALF(DH)) i_sync_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .xfer_ack(xfer_ack), .sclk_o(sclk_o), .txd_o(txd_o), .rxd_i(rxd_i),
    .txe_irq_o(txe_irq_o), .rxf_irq_o(rxf_irq_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx_exp[$], rx_exp[$], rx_src[$];
  bit   tx_mon_on = 0;
  int   mon_cnt = 0, rx_cnt = 0, n_fall = 0, n_txe_irq = 0, n_rxf_irq = 0;
  logic [7:0] mon_sh = '0, cur_rx = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: serial output, compared on rising sclk
  always @(posedge sclk_o) begin
    #1;
    if (tx_mon_on) begin
      mon_sh = {txd_o, mon_sh[7:1]};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (tx_exp.size() == 0) chk(0, "R3 unexpected tx frame", mon_sh, 0);
        else begin
          logic [7:0] e;
          e = tx_exp.pop_front();
          chk(mon_sh == e, "R2 tx byte", mon_sh, e);
        end
      end
    end
  end

  // serial input driver: pushes expected receive bytes
  always @(negedge sclk_o) begin
    n_fall++;
    if (rx_cnt == 0) begin
      cur_rx = (rx_src.size() > 0) ? rx_src.pop_front() : 8'h3C;
      rx_exp.push_back(cur_rx);
    end
    rxd_i  = cur_rx[rx_cnt];
    rx_cnt = (rx_cnt + 1) % 8;
  end

  always @(negedge clk) begin
    if (txe_irq_o) n_txe_irq++;
    if (rxf_irq_o) n_rxf_irq++;
  end

  task automatic host_read(input logic [1:0] a, input logic ack, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a; xfer_ack = ack;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; xfer_ack = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] v, input logic ack);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = v; xfer_ack = ack;
    @(negedge clk);
    host_wr = 1'b0; xfer_ack = 1'b0;
  endtask

  task automatic do_reset();
    tx_mon_on = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    tx_exp.delete(); rx_exp.delete(); rx_src.delete();
    mon_cnt = 0; rx_cnt = 0; n_fall = 0; n_txe_irq = 0; n_rxf_irq = 0;
    rxd_i = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic poll_stat(input logic [7:0] mask, output logic [7:0] st);
    st = '0;
    for (int g = 0; g < 400; g++) begin
      host_read(2'd1, 1'b0, st);
      if ((st & mask) != 0) break;
    end
  endtask

  task automatic wait_rxf_irq(input int target);
    for (int g = 0; g < 600 && n_rxf_irq < target; g++) @(negedge clk);
  endtask

  task automatic pop_rx(output logic [7:0] e);
    if (rx_exp.size() == 0) begin
      chk(0, "R6 rx scoreboard empty", 0, 1);
      e = '0;
    end else e = rx_exp.pop_front();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] st, d, e;
    int cnt, f0;

    // R1 / R11: reset state and register map
    do_reset();
    host_read(2'd1, 1'b0, st); chk(st == 8'h01, "R1 status after reset", st, 8'h01);
    host_read(2'd0, 1'b0, d);  chk(d == 8'h00, "R11 control after reset", d, 0);
    chk(txd_o && sclk_o, "R1 lines idle high", {txd_o, sclk_o}, 3);

    // R4: enable rule
    host_write(2'd0, 8'h01, 0); host_write(2'd0, 8'h03, 0);
    host_read(2'd0, 1'b0, d); chk(d == 8'h01, "R4 refused from tx-only", d, 1);
    host_write(2'd0, 8'h00, 0); host_write(2'd0, 8'h03, 0);
    host_read(2'd0, 1'b0, d); chk(d == 8'h03, "R4 accepted from idle", d, 3);
    do_reset();
    host_write(2'd0, 8'h02, 0); host_write(2'd0, 8'h03, 0);
    host_read(2'd0, 1'b0, d); chk(d == 8'h02, "R4 refused from rx-only", d, 2);

    // R8 / R2 / R5: flag clear protocol and bit timing, tx only
    do_reset();
    host_write(2'd0, 8'h01, 0);
    tx_mon_on = 1;
    host_write(2'd2, 8'h96, 0);
    host_read(2'd2, 1'b0, d); chk(d == 8'h96, "R11 tx data readback", d, 8'h96);
    host_write(2'd1, 8'h00, 0);
    repeat (20) @(negedge clk);
    chk(n_fall == 0, "R8 no clear without prior read", n_fall, 0);
    host_read(2'd1, 1'b0, st); chk(st[0] == 1'b1, "R8 txe still set", st, 1);
    host_write(2'd1, 8'h01, 0);
    repeat (10) @(negedge clk);
    chk(n_fall == 0, "R8 write one keeps flag", n_fall, 0);
    tx_exp.push_back(8'h96);
    host_write(2'd1, 8'h00, 0);
    @(negedge sclk_o);
    cnt = 0;
    while (!sclk_o) begin
      @(negedge clk);
      if (!sclk_o) cnt++;
    end
    chk(cnt == DH, "R2 low half length", cnt, DH);
    repeat (100) @(negedge clk);
    chk(tx_exp.size() == 0, "R2 tx frame seen", tx_exp.size(), 0);
    chk(n_txe_irq == 1, "R5 txe request on load", n_txe_irq, 1);

    // R3 / R5 / R6 / R9: full-duplex streaming
    do_reset();
    host_write(2'd0, 8'h03, 0);
    tx_mon_on = 1;
    for (int i = 0; i < 6; i++) rx_src.push_back(8'(i * 37 + 5));
    begin
      int sent, got;
      sent = 1; got = 0;
      tx_exp.push_back(8'hC3);
      host_write(2'd2, 8'hC3, 1);
      for (int g = 0; g < 4000 && got < 6; g++) begin
        host_read(2'd1, 1'b0, st);
        if (st[1]) begin
          host_read(2'd3, 1'b1, d);
          pop_rx(e);
          chk(d == e, "R6 rx byte", d, e);
          got++;
        end
        if (st[0] && sent < 6) begin
          tx_exp.push_back(8'(8'hC3 ^ (sent * 19)));
          host_write(2'd2, 8'(8'hC3 ^ (sent * 19)), 1);
          sent++;
        end
      end
      chk(got == 6, "R3 full-duplex stream complete", got, 6);
    end
    host_read(2'd1, 1'b0, st); chk(st[1] == 1'b0, "R9 rx read with ack clears", st, 0);
    repeat (100) @(negedge clk);
    chk(tx_exp.size() == 0, "R3 all tx bytes sent", tx_exp.size(), 0);
    chk(n_txe_irq == 6, "R5 txe request count", n_txe_irq, 6);
    chk(n_rxf_irq == 6, "R6 rxf request count", n_rxf_irq, 6);
    chk(sclk_o && txd_o, "R2 idle after stream", {sclk_o, txd_o}, 3);

    // R7 / R8 / R9: overrun, freeze and recovery
    do_reset();
    host_write(2'd0, 8'h03, 0);
    tx_mon_on = 1;
    rx_src.push_back(8'h11); rx_src.push_back(8'h22); rx_src.push_back(8'h33);
    tx_exp.push_back(8'hA1); host_write(2'd2, 8'hA1, 1);
    wait_rxf_irq(1);
    host_write(2'd1, 8'h00, 0);
    host_read(2'd1, 1'b0, st); chk(st == 8'h03, "R8 rxf kept without prior read", st, 3);
    tx_exp.push_back(8'hA2); host_write(2'd2, 8'hA2, 1);
    poll_stat(8'h04, st);
    chk(st[2] == 1'b1, "R7 overrun set", st, 4);
    host_read(2'd3, 1'b0, d); chk(d == 8'h11, "R7 rx register keeps older byte", d, 8'h11);
    tx_exp.push_back(8'hA3); host_write(2'd2, 8'hA3, 1);
    host_read(2'd1, 1'b0, st); chk(st == 8'h06, "R9 tx write with ack clears txe", st, 6);
    f0 = n_fall;
    repeat (200) @(negedge clk);
    chk(n_fall == f0 && sclk_o, "R7 both directions frozen", n_fall - f0, 0);
    host_write(2'd1, 8'h07, 0);
    host_read(2'd1, 1'b0, st); chk(st == 8'h06, "R8 write one leaves flags", st, 6);
    host_read(2'd3, 1'b1, d); pop_rx(e); chk(d == e, "R7 first byte intact", d, e);
    pop_rx(e);
    host_write(2'd1, 8'h03, 0);
    host_read(2'd1, 1'b0, st); chk(st[2] == 1'b0, "R8 overrun cleared", st, 0);
    poll_stat(8'h02, st);
    host_read(2'd3, 1'b1, d); pop_rx(e); chk(d == e && d == 8'h33, "R7 resumed rx byte", d, 8'h33);
    repeat (40) @(negedge clk);
    chk(tx_exp.size() == 0, "R7 tx resumed", tx_exp.size(), 0);
    chk(n_rxf_irq == 2, "R6 no request for lost frame", n_rxf_irq, 2);

    // R10: disabling transmit forces empty
    do_reset();
    host_write(2'd0, 8'h03, 0);
    tx_mon_on = 1;
    tx_exp.push_back(8'h5A); host_write(2'd2, 8'h5A, 1);
    host_write(2'd2, 8'hE7, 1);
    host_read(2'd1, 1'b0, st); chk(st[0] == 1'b0, "R9 pending byte clears txe", st, 0);
    host_write(2'd0, 8'h00, 0);
    host_read(2'd1, 1'b0, st); chk(st[0] == 1'b1, "R10 txe set after disable", st, 1);
    repeat (120) @(negedge clk);
    chk(tx_exp.size() == 0, "R10 only first byte sent", tx_exp.size(), 0);

    // R3: receive-only frames run without tx data
    do_reset();
    rx_src.push_back(8'h6D);
    host_write(2'd0, 8'h02, 0);
    wait_rxf_irq(1);
    chk(txd_o == 1'b1, "R3 txd high in rx-only", txd_o, 1);
    host_read(2'd3, 1'b1, d); chk(d == 8'h6D, "R3 rx-only byte", d, 8'h6D);
    host_write(2'd0, 8'h00, 0);
    repeat (80) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule